// File: doc/BRIEF.md
# Device Status Interrupt Controller

This block collects six health flags of a clock-generation device (primary and secondary reference loss of signal, PLL loss of lock, calibration in progress, EEPROM busy and automatic secondary-to-primary switchover) and turns them into an active-high interrupt. It also drives two status pins. Each pin picks, through a 4-bit selector, one of the flags, one of three divide-by-two divider monitors, or the interrupt.

Software reaches the block through a simple register port. It sets a global interrupt enable, an AND/OR combine mode, per-source masks and the configuration of each pin. It can read two status registers. The latched register records flag rising edges only while the global enable is set. The real-time register records flag levels whatever the enable is. Both clear themselves when they are read.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset every configuration and status register reads 0, and `irq_o`, `stat_o` and `reg_rdata_o` are low.
- R2: A write takes effect at the clock edge where `reg_we_i` is sampled high. A read returns data on `reg_rdata_o` in the cycle after the edge where `reg_re_i` is sampled high. Otherwise `reg_rdata_o` is 0. The map is:
  - address 0: control, bit0 global enable, bit1 combine mode.
  - addresses 1 and 2: pin 0 and pin 1 configuration, bit0 pin enable, bits[3:1] function, bits[7:4] selector.
  - address 3: mask, bits[5:0].
  - address 4: latched status.
  - address 5: real-time status.
  - addresses 6 and 7: read as 0.
  - Unused bits read 0.
- R3: Flag bits are ordered as follows in `flags_i`, the mask and both status registers: bit0 primary LOS, bit1 secondary LOS, bit2 loss of lock, bit3 calibration, bit4 EEPROM, bit5 switchover. While the global enable is 1, a 0-to-1 change of a flag sets its latched bit, and the bit stays set until the register is read.
- R4: While the global enable is 0, the latched register captures no event, and reading address 4 returns 0.
- R5: Reading address 4 while enabled returns the current contents and clears them. A flag event in the same cycle as that clear stays set.
- R6: A real-time bit is set in every cycle its flag is high, whatever the global enable is. Reading address 5 clears the register, and a flag that is still high sets its bit again.
- R7: A mask bit of 1 excludes that source from the interrupt.
- R8: `irq_o` is active high and is 0 whenever the global enable is 0. With mode 0 it is the OR of the unmasked latched bits. With mode 1 it is the AND of the unmasked latched bits, and it is 0 when every source is masked.
- R9: A pin with enable 1 shows the source its selector names. The selector codes are: 0 primary LOS, 1 secondary LOS, 2 loss of lock, 3 R divider /2, 4 N divider /2, 8 calibration, 10 interrupt, 11 M divider /2, 13 EEPROM, 14 switchover. Code 10 shows the interrupt only when the function field is 3'b111, and shows 0 otherwise.
- R10: A pin with enable 0, or a pin set to a reserved code (5, 6, 7, 9, 12, 15), drives 0.
- R11: Each divider monitor starts at 0 and toggles on every clock where its pulse input is high. In `div_pulse_i`, bit0 is R, bit1 is N and bit2 is M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flags_i | input | 6 | Health flags, ordered as in R3 |
| div_pulse_i | input | 3 | Divider output pulses (R, N, M) |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Combined interrupt, active high |
| stat_o | output | 2 | Status pins |

## Verification
The hardest case to reach is a flag rising edge that lands in the very clock where a latched-register read clears the bits. The bench raises the flag and asserts the read strobe from the same falling edge, then checks two things: the read returns the old contents, and the next read shows the new event. The AND combine with masks also needs many latched patterns, so every mask is swept against every latched pattern. Each pattern is rebuilt by clearing through a read and then raising the flags from zero.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int NUM_PINS  = 2;
  localparam int NUM_DIV   = 3;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int SEL_W     = 4;
  localparam int FUNC_W    = 3;
  localparam int NUM_SEL   = 1 << SEL_W;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_PIN  = 1;
  localparam int ADDR_MASK = ADDR_PIN + NUM_PINS;
  localparam int ADDR_LAT  = ADDR_MASK + 1;
  localparam int ADDR_RT   = ADDR_LAT + 1;

  localparam int FLG_PRI_LOS = 0;
  localparam int FLG_SEC_LOS = 1;
  localparam int FLG_LOL     = 2;
  localparam int FLG_CAL     = 3;
  localparam int FLG_EEPROM  = 4;
  localparam int FLG_SWITCH  = 5;

  localparam int DIV_R = 0;
  localparam int DIV_N = 1;
  localparam int DIV_M = 2;

  localparam int SEL_PRI_LOS = 0;
  localparam int SEL_SEC_LOS = 1;
  localparam int SEL_LOL     = 2;
  localparam int SEL_RDIV    = 3;
  localparam int SEL_NDIV    = 4;
  localparam int SEL_CAL     = 8;
  localparam int SEL_INTR    = 10;
  localparam int SEL_MDIV    = 11;
  localparam int SEL_EEPROM  = 13;
  localparam int SEL_SWITCH  = 14;

  localparam logic [NUM_SEL-1:0] RSVD_MASK  = 16'h92E0;
  localparam logic [FUNC_W-1:0]  FUNC_INTR  = 3'b111;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [FUNC_W-1:0] func;
    logic              en;
  } pin_cfg_t;
endpackage

// File: rtl/stat_irq_regs.sv
module stat_irq_regs
  import stat_irq_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_FLAGS-1:0]          flags_i,
  input  logic                          we_i,
  input  logic                          re_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          gie_o,
  output logic                          and_mode_o,
  output logic [NUM_FLAGS-1:0]          mask_o,
  output pin_cfg_t [NUM_PINS-1:0]       pin_cfg_o,
  output logic [NUM_FLAGS-1:0]          lat_o
);
  logic                 gie_q, and_q;
  logic [NUM_FLAGS-1:0] mask_q, lat_q, rt_q, flags_q, ev;
  pin_cfg_t [NUM_PINS-1:0] pin_q;
  logic [DATA_W-1:0]    rd_val, rdata_q;
  logic                 hit_ctrl, hit_mask, hit_lat, hit_rt;
  logic                 clr_lat, clr_rt;

  assign hit_ctrl = addr_i == ADDR_W'(ADDR_CTRL);
  assign hit_mask = addr_i == ADDR_W'(ADDR_MASK);
  assign hit_lat  = addr_i == ADDR_W'(ADDR_LAT);
  assign hit_rt   = addr_i == ADDR_W'(ADDR_RT);

  assign ev      = gie_q ? (flags_i & ~flags_q) : '0;
  assign clr_lat = re_i && hit_lat && gie_q;
  assign clr_rt  = re_i && hit_rt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q   <= 1'b0;
      and_q   <= 1'b0;
      mask_q  <= '0;
      flags_q <= '0;
      lat_q   <= '0;
      rt_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i && hit_ctrl) begin
        gie_q <= wdata_i[0];
        and_q <= wdata_i[1];
      end
      if (we_i && hit_mask) mask_q <= wdata_i[NUM_FLAGS-1:0];
      flags_q <= flags_i;
      // set wins over clear so a coincident event survives the read
      lat_q   <= (lat_q & ~{NUM_FLAGS{clr_lat}}) | ev;
      rt_q    <= (rt_q & ~{NUM_FLAGS{clr_rt}}) | flags_i;
      rdata_q <= re_i ? rd_val : '0;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_q[p] <= '0;
      else if (we_i && addr_i == ADDR_W'(ADDR_PIN + p)) pin_q[p] <= pin_cfg_t'(wdata_i);
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctrl) rd_val = DATA_W'({and_q, gie_q});
    if (hit_mask) rd_val = DATA_W'(mask_q);
    if (hit_lat)  rd_val = gie_q ? DATA_W'(lat_q) : '0;
    if (hit_rt)   rd_val = DATA_W'(rt_q);
    for (int p = 0; p < NUM_PINS; p++)
      if (addr_i == ADDR_W'(ADDR_PIN + p)) rd_val = DATA_W'(pin_q[p]);
  end

  assign rdata_o    = rdata_q;
  assign gie_o      = gie_q;
  assign and_mode_o = and_q;
  assign mask_o     = mask_q;
  assign pin_cfg_o  = pin_q;
  assign lat_o      = lat_q;

  p_no_capture_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |=> (lat_q & ~$past(lat_q)) == '0);
  p_ev_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev != '0 |=> (lat_q & $past(ev)) == $past(ev));
  p_rt_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rt_q & $past(flags_i)) == $past(flags_i));
  p_lat_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_lat |=> (lat_q & ~$past(ev)) == '0);
endmodule

// File: rtl/stat_irq_combine.sv
module stat_irq_combine
  import stat_irq_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] lat_i,
  input  logic [NUM_FLAGS-1:0] mask_i,
  input  logic                 gie_i,
  input  logic                 and_mode_i,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] live;
  logic any_live, or_hit, and_hit;

  assign live     = ~mask_i;
  assign any_live = |live;
  assign or_hit   = |(lat_i & live);
  // masked sources count as satisfied in AND mode
  assign and_hit  = any_live && (&(lat_i | mask_i));
  assign irq_o    = gie_i && (and_mode_i ? and_hit : or_hit);
endmodule

// File: rtl/stat_pin_mux.sv
module stat_pin_mux
  import stat_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pin_cfg_t           cfg_i,
  input  logic [NUM_SEL-1:0] src_i,
  output logic               pin_o
);
  logic rsvd, intr_sel, intr_ok;

  assign rsvd     = RSVD_MASK[cfg_i.sel];
  assign intr_sel = cfg_i.sel == SEL_W'(SEL_INTR);
  assign intr_ok  = cfg_i.func == FUNC_INTR;
  assign pin_o    = cfg_i.en && !rsvd && (!intr_sel || intr_ok) && src_i[cfg_i.sel];

  p_rsvd_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RSVD_MASK[cfg_i.sel] || !cfg_i.en) |-> !pin_o);
  p_intr_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.sel == SEL_W'(SEL_INTR) && cfg_i.func != FUNC_INTR) |-> !pin_o);
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_DIV-1:0]   div_pulse_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  output logic [NUM_PINS-1:0]  stat_o
);
  logic                    gie, and_mode, irq;
  logic [NUM_FLAGS-1:0]    mask, lat;
  pin_cfg_t [NUM_PINS-1:0] pin_cfg;
  logic [NUM_DIV-1:0]      div_q;
  logic [NUM_SEL-1:0]      src;

  stat_irq_regs u_regs (
    .clk_i, .rst_ni, .flags_i,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .gie_o(gie), .and_mode_o(and_mode),
    .mask_o(mask), .pin_cfg_o(pin_cfg), .lat_o(lat)
  );

  stat_irq_combine u_comb (
    .lat_i(lat), .mask_i(mask), .gie_i(gie), .and_mode_i(and_mode), .irq_o(irq)
  );

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q[d] <= 1'b0;
      else if (div_pulse_i[d]) div_q[d] <= ~div_q[d];
    end
    p_div_toggle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_pulse_i[d] |=> div_q[d] != $past(div_q[d]));
  end

  always_comb begin
    src = '0;
    src[SEL_PRI_LOS] = flags_i[FLG_PRI_LOS];
    src[SEL_SEC_LOS] = flags_i[FLG_SEC_LOS];
    src[SEL_LOL]     = flags_i[FLG_LOL];
    src[SEL_RDIV]    = div_q[DIV_R];
    src[SEL_NDIV]    = div_q[DIV_N];
    src[SEL_CAL]     = flags_i[FLG_CAL];
    src[SEL_INTR]    = irq;
    src[SEL_MDIV]    = div_q[DIV_M];
    src[SEL_EEPROM]  = flags_i[FLG_EEPROM];
    src[SEL_SWITCH]  = flags_i[FLG_SWITCH];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    stat_pin_mux u_mux (
      .clk_i, .rst_ni, .cfg_i(pin_cfg[p]), .src_i(src), .pin_o(stat_o[p])
    );
  end

  assign irq_o = irq;

  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie |-> !irq_o);
  p_irq_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!and_mode && (lat & ~mask) == '0) |-> !irq_o);
endmodule

// File: tb/stat_irq_ctrl_tb_top.sv
module stat_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] flags = '0;
  logic [2:0] div_pulse = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] stat;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] dv = '0;

  always #5ns clk = ~clk;

  stat_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flags_i(flags), .div_pulse_i(div_pulse),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .stat_o(stat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk); re = 1'b1; addr = 3'(a);
    @(posedge clk); #1; v = rdata; re = 1'b0;
  endtask

  task automatic set_flags(input logic [5:0] f);
    @(negedge clk); flags = f;
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int d);
    @(negedge clk); div_pulse = 3'(1 << d);
    @(posedge clk); #1; div_pulse = '0;
    dv[d] = ~dv[d];
  endtask

  function automatic logic exp_pin(input logic [7:0] cfg, input logic [5:0] f,
                                   input logic [2:0] d, input logic ir);
    if (!cfg[0]) return 1'b0;
    case (cfg[7:4])
      4'd0:  return f[0];
      4'd1:  return f[1];
      4'd2:  return f[2];
      4'd3:  return d[0];
      4'd4:  return d[1];
      4'd8:  return f[3];
      4'd10: return (cfg[3:1] == 3'b111) ? ir : 1'b0;
      4'd11: return d[2];
      4'd13: return f[4];
      4'd14: return f[5];
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #1.5ms;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(irq == 1'b0 && stat == 2'b00, "R1 outputs", {irq, stat}, 0);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    @(negedge clk); rst_ni = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk(v == 8'h00, "R1 reg", v, 0);
    end
    // R2 readback
    wr(0, 8'hFC); rd(0, v); chk(v == 8'h00, "R2 ctrl", v, 0);
    wr(1, 8'hA5); rd(1, v); chk(v == 8'hA5, "R2 pin0", v, 8'hA5);
    wr(2, 8'h5A); rd(2, v); chk(v == 8'h5A, "R2 pin1", v, 8'h5A);
    wr(3, 8'hFF); rd(3, v); chk(v == 8'h3F, "R2 mask", v, 8'h3F);
    wr(6, 8'hFF); rd(6, v); chk(v == 8'h00, "R2 unused", v, 0);
    @(negedge clk); chk(rdata == 8'h00, "R2 idle rdata", rdata, 0);
    wr(1, 0); wr(2, 0); wr(3, 0);
    // R4 disabled capture, R6 real-time ignores enable
    set_flags(6'h3F);
    rd(4, v); chk(v == 8'h00, "R4 read while off", v, 0);
    rd(5, v); chk(v == 8'h3F, "R6 rt while off", v, 8'h3F);
    chk(irq == 1'b0, "R8 irq off", irq, 0);
    wr(0, 1);
    rd(4, v); chk(v == 8'h00, "R4 no late capture", v, 0);
    // R3 per-flag capture, R5 clear on read
    for (int i = 0; i < 6; i++) begin
      set_flags(0); rd(4, v);
      set_flags(6'(1 << i));
      set_flags(0);
      rd(4, v); chk(v == 8'(1 << i), "R3 capture", v, 1 << i);
      rd(4, v); chk(v == 8'h00, "R5 cleared", v, 0);
    end
    // R5 event in the clearing cycle
    set_flags(6'h01);
    @(negedge clk); flags = 6'h05; re = 1'b1; addr = 3'd4;
    @(posedge clk); #1; v = rdata; re = 1'b0;
    chk(v == 8'h01, "R5 old value", v, 8'h01);
    rd(4, v); chk(v == 8'h04, "R5 coincident kept", v, 8'h04);
    // R6 real-time behaviour
    rd(5, v);
    set_flags(6'h05);
    rd(5, v); chk(v == 8'h05, "R6 level", v, 8'h05);
    rd(5, v); chk(v == 8'h05, "R6 reasserted", v, 8'h05);
    set_flags(0);
    rd(5, v); chk(v == 8'h05, "R6 held", v, 8'h05);
    rd(5, v); chk(v == 8'h00, "R6 cleared", v, 0);
    // R7 R8 exhaustive mask x pattern
    for (int m = 0; m < 64; m++) begin
      wr(3, m);
      for (int p = 0; p < 64; p++) begin
        logic e_or, e_and;
        e_or  = |(6'(p) & ~6'(m));
        e_and = (~6'(m) != 6'h0) && ((6'(p) | 6'(m)) == 6'h3F);
        set_flags(0); rd(4, v);
        set_flags(6'(p));
        wr(0, 1); chk(irq == e_or, "R7 R8 or", irq, e_or);
        wr(0, 3); chk(irq == e_and, "R7 R8 and", irq, e_and);
      end
    end
    wr(0, 2); chk(irq == 1'b0, "R8 gated", irq, 0);
    wr(3, 0); wr(0, 1);
    // R9 R10 pin matrix
    for (int k = 0; k < 4; k++) begin
      logic [5:0] pat;
      pat = (k == 0) ? 6'h00 : (k == 1) ? 6'h2A : (k == 2) ? 6'h15 : 6'h3F;
      set_flags(0); rd(4, v);
      set_flags(pat);
      pulse(k % 3);
      for (int pin = 0; pin < 2; pin++)
        for (int s = 0; s < 16; s++)
          for (int e = 0; e < 2; e++)
            for (int fn = 0; fn < 2; fn++) begin
              logic [7:0] cfg;
              logic ex;
              cfg = {4'(s), (fn == 1) ? 3'b111 : 3'b011, 1'(e)};
              ex = exp_pin(cfg, pat, dv, |pat);
              wr(1 + pin, cfg);
              chk(stat[pin] == ex, "R9 R10 pin", stat[pin], ex);
              chk(stat[1-pin] == 1'b0, "R10 other pin", stat[1-pin], 0);
            end
      wr(1, 0); wr(2, 0);
    end
    // R11 divider toggle via pin
    wr(1, 8'h31);
    for (int t = 0; t < 4; t++) begin
      pulse(0);
      chk(stat[0] == dv[0], "R11 toggle", stat[0], dv[0]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule